// File: doc/BRIEF.md
# Zone Command Register with Identifier Readout

This block holds the command state of one 128 KB zone of a flash memory card. The host writes commands over the card bus. The target address is taken when the write strobe goes low while the card select is active. The command data is taken when the strobe goes high again. A command only counts when the captured address falls inside this zone. In word-wide mode the decode covers the pair of adjacent zones that share a word. The register also decodes writes aimed at the zone for the erase and program engines, which are not part of this block.

Two modes are held: array read and identifier read. In array read, the read path passes the memory array data straight through. In identifier read, the read path returns fixed manufacturer and device codes at zone offsets 0 and 2. The block accepts commands only while the programming supply is present and the write-protect switch is off. When the supply is lost, the zone drops back to array read.

All bus inputs are synchronous to `clk`. The strobe edges are found by sampling the strobe on the clock. A mode change is visible at the clock edge that sees the strobe high.

Top module: `zone_cmd_reg`

## Requirements
- R1: After reset the zone is in array read: `mode_id` is 0 and `rdata` equals `array_rdata`.
- R2: While `vpp_ok` is low, `mode_id` is 0 and every write is ignored.
- R3: A write with code 90h in the low data byte enters identifier mode when `wide`=0, and the high byte is ignored. When `wide`=1 the full word must be 9090h.
- R4: In identifier mode, `rdata` returns 0089h (8989h when `wide`=1) at zone offset 0 and 00B4h (B4B4h when `wide`=1) at zone offset 2. It returns 0000h at any other offset. The zone offset is `bus_addr[16:0]`.
- R5: A write of 00h in the low byte (0000h when `wide`=1) selects array read. The zone stays in array read until another accepted command is written.
- R6: A write whose code is not recognised leaves the mode unchanged. With `wide`=1, a word whose two bytes differ is not recognised.
- R7: While `wp_sw` is high, no write reaches the register, including a strobe already low when `wp_sw` rises.
- R8: The target address is taken at the falling strobe while `ce_n` is low, and the data at the rising strobe. A strobe that falls while `ce_n` is high is ignored.
- R9: A command is accepted only if the zone field `bus_addr[19:17]` at the falling strobe equals the zone index (3). When `wide`=1, only bits [19:18] are compared.
- R10: When `vpp_ok` falls, the zone returns to array read without any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_ok | input | 1 | Programming supply present |
| wp_sw | input | 1 | Write-protect switch active |
| wide | input | 1 | 1 = word-wide encoding, 0 = byte-wide |
| ce_n | input | 1 | Card select, active low |
| we_n | input | 1 | Write strobe, active low |
| bus_addr | input | 20 | Byte address of the card bus |
| bus_wdata | input | 16 | Write data |
| array_rdata | input | 16 | Data from the memory array |
| rdata | output | 16 | Read data to the bus |
| mode_id | output | 1 | 1 when identifier mode is active |

## Verification
The bench goes after the following corner cases:
- An address that changes between the falling and rising strobe. A design that took the address late would obey or drop commands based on the wrong zone.
- Byte-mode writes with a non-zero high byte, and word-mode words with mismatched bytes. A decoder that looked at the wrong byte lanes would enter or leave identifier mode by mistake.
- The write-protect switch rising in the middle of a strobe. This must not be read as a rising edge that commits the command.
- Loss of the programming supply while in identifier mode. A design that missed it would keep returning identifier codes instead of array data.

// File: rtl/zcr_pkg.sv
package zcr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_IDENT = 2'd2
  } cmd_e;

  typedef enum logic {
    MODE_ARRAY = 1'b0,
    MODE_IDENT = 1'b1
  } mode_e;

  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_IDENT = 8'h90;
  localparam logic [7:0] CODE_MFR = 8'h89;
  localparam logic [7:0] CODE_DEV = 8'hB4;
endpackage

// File: rtl/zcr_bus_capture.sv
module zcr_bus_capture #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic          wp_sw,
  input  logic          vpp_ok,
  input  logic [AW-1:0] bus_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr
);
  // switch forces the internal strobe inactive
  logic we_int, we_q;
  logic fall, rise;
  logic armed_q, armed_d;
  logic [AW-1:0] addr_q, addr_d;

  assign we_int = we_n | wp_sw;
  assign fall   = we_q & ~we_int;
  assign rise   = ~we_q & we_int;

  always_comb begin
    armed_d = armed_q;
    addr_d  = addr_q;
    if (!vpp_ok) begin
      armed_d = 1'b0;
    end else if (fall) begin
      armed_d = ~ce_n;
      if (!ce_n) addr_d = bus_addr;
    end else if (rise) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      we_q    <= we_int;
      armed_q <= armed_d;
      addr_q  <= addr_d;
    end
  end

  assign wr_stb  = rise & armed_q & ~wp_sw & vpp_ok;
  assign wr_addr = addr_q;
endmodule

// File: rtl/zcr_cmd_decode.sv
module zcr_cmd_decode
  import zcr_pkg::*;
(
  input  logic [15:0] wdata,
  input  logic        wide,
  output cmd_e        cmd
);
  logic lanes_ok;

  // word-wide commands carry the same opcode in both byte lanes
  assign lanes_ok = !wide || (wdata[15:8] == wdata[7:0]);

  always_comb begin
    cmd = CMD_NONE;
    if (lanes_ok) begin
      unique case (wdata[7:0])
        OP_READ:  cmd = CMD_READ;
        OP_IDENT: cmd = CMD_IDENT;
        default:  cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/zcr_zone_match.sv
module zcr_zone_match #(
  parameter int AW       = 20,
  parameter int ZONE_LSB = 17,
  parameter int ZONE_IDX = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          wide,
  output logic          hit
);
  localparam int ZW = AW - ZONE_LSB;
  localparam logic [ZW-1:0] ZID = ZW'(ZONE_IDX);

  logic [ZW-1:0] zfield;
  logic          hit_byte, hit_word;

  assign zfield   = addr[AW-1:ZONE_LSB];
  assign hit_byte = (zfield == ZID);

  generate
    if (ZW > 1) begin : g_pair
      assign hit_word = (zfield[ZW-1:1] == ZID[ZW-1:1]);
    end else begin : g_single
      assign hit_word = 1'b1;
    end
  endgenerate

  assign hit = wide ? hit_word : hit_byte;
endmodule

// File: rtl/zcr_id_mux.sv
module zcr_id_mux
  import zcr_pkg::*;
#(
  parameter int OW = 17
) (
  input  mode_e         mode,
  input  logic          wide,
  input  logic [OW-1:0] offset,
  input  logic [15:0]   array_rdata,
  output logic [15:0]   rdata
);
  logic [7:0] code;

  always_comb begin
    if (offset == OW'(0))      code = CODE_MFR;
    else if (offset == OW'(2)) code = CODE_DEV;
    else                       code = 8'h00;
  end

  always_comb begin
    if (mode == MODE_ARRAY) rdata = array_rdata;
    else                    rdata = {(wide ? code : 8'h00), code};
  end
endmodule

// File: rtl/zone_cmd_reg.sv
module zone_cmd_reg
  import zcr_pkg::*;
#(
  parameter int AW       = 20,
  parameter int ZONE_LSB = 17,
  parameter int ZONE_IDX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_ok,
  input  logic          wp_sw,
  input  logic          wide,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic [15:0]   array_rdata,
  output logic [15:0]   rdata,
  output logic          mode_id
);
  logic rst_s1, rst_s2;
  logic wr_stb, zone_hit, cmd_en;
  logic [AW-1:0] wr_addr;
  cmd_e  cmd;
  mode_e mode_q, mode_d;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  zcr_bus_capture #(.AW(AW)) cap_i (
    .clk(clk), .rst_ni(rst_s2), .we_n(we_n), .ce_n(ce_n),
    .wp_sw(wp_sw), .vpp_ok(vpp_ok), .bus_addr(bus_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr)
  );

  zcr_zone_match #(.AW(AW), .ZONE_LSB(ZONE_LSB), .ZONE_IDX(ZONE_IDX)) zm_i (
    .addr(wr_addr), .wide(wide), .hit(zone_hit)
  );

  zcr_cmd_decode dec_i (
    .wdata(bus_wdata), .wide(wide), .cmd(cmd)
  );

  assign cmd_en = wr_stb & zone_hit;

  always_comb begin
    mode_d = mode_q;
    if (!vpp_ok) begin
      mode_d = MODE_ARRAY;
    end else if (cmd_en) begin
      unique case (cmd)
        CMD_READ:  mode_d = MODE_ARRAY;
        CMD_IDENT: mode_d = MODE_IDENT;
        default:   mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) mode_q <= MODE_ARRAY;
    else         mode_q <= mode_d;
  end

  zcr_id_mux #(.OW(ZONE_LSB)) mux_i (
    .mode(mode_q), .wide(wide), .offset(bus_addr[ZONE_LSB-1:0]),
    .array_rdata(array_rdata), .rdata(rdata)
  );

  assign mode_id = (mode_q == MODE_IDENT);
endmodule

// File: rtl/zcr_checker.sv
module zcr_checker #(
  parameter int AW       = 20,
  parameter int ZONE_LSB = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vpp_ok,
  input logic          wp_sw,
  input logic          wide,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   array_rdata,
  input logic [15:0]   rdata,
  input logic          mode_id
);
  assert_no_write_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> !mode_id);

  assert_array_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_id |-> rdata == array_rdata);

  assert_mfr_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_id && bus_addr[ZONE_LSB-1:0] == '0) |-> rdata == (wide ? 16'h8989 : 16'h0089));

  assert_dev_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_id && bus_addr[ZONE_LSB-1:0] == ZONE_LSB'(2)) |-> rdata == (wide ? 16'hB4B4 : 16'h00B4));

  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_sw && vpp_ok) |=> $stable(mode_id));

  assert_entry_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_id) |-> $past(vpp_ok && !wp_sw));
endmodule

bind zone_cmd_reg zcr_checker #(.AW(AW), .ZONE_LSB(ZONE_LSB)) chk_i (
  .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .wp_sw(wp_sw), .wide(wide),
  .bus_addr(bus_addr), .array_rdata(array_rdata), .rdata(rdata), .mode_id(mode_id)
);

// File: tb/zone_cmd_reg_tb_top.sv
`timescale 1ns/1ps
module zone_cmd_reg_tb_top;
  localparam int ZIDX = 3;

  logic clk = 1'b0;
  logic rst_n, vpp_ok, wp_sw, wide, ce_n, we_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, array_rdata, rdata;
  logic mode_id;

  int total = 0;
  int bad = 0;
  bit exp_id = 1'b0;

  always #4 clk = ~clk;

  zone_cmd_reg dut_i (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .wp_sw(wp_sw), .wide(wide),
    .ce_n(ce_n), .we_n(we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .array_rdata(array_rdata), .rdata(rdata), .mode_id(mode_id)
  );

  function automatic bit zone_ok(input logic [19:0] a, input bit wd);
    logic [2:0] z = ZIDX;
    return wd ? (a[19:18] == z[2:1]) : (a[19:17] == z);
  endfunction

  function automatic int code_of(input logic [15:0] d, input bit wd);
    // 0 = read, 1 = ident, 2 = unrecognised
    if (wd && d[15:8] != d[7:0]) return 2;
    if (d[7:0] == 8'h00) return 0;
    if (d[7:0] == 8'h90) return 1;
    return 2;
  endfunction

  function automatic logic [15:0] exp_rd(input bit id, input bit wd,
                                         input logic [16:0] off, input logic [15:0] arr);
    if (!id) return arr;
    if (off == 17'd0) return wd ? 16'h8989 : 16'h0089;
    if (off == 17'd2) return wd ? 16'hB4B4 : 16'h00B4;
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [19:0] a_fall, input logic [19:0] a_rise,
                          input logic [15:0] d, input bit ce_lo, input bit wp);
    int c;
    @(negedge clk); wp_sw = wp; ce_n = !ce_lo; bus_addr = a_fall; we_n = 1'b0;
    @(negedge clk); bus_addr = a_rise;
    @(negedge clk); bus_wdata = d; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; wp_sw = 1'b0; bus_wdata = 16'($urandom);
    c = code_of(d, wide);
    if (ce_lo && !wp && vpp_ok && zone_ok(a_fall, wide) && c != 2) exp_id = (c == 1);
  endtask

  task automatic check_reads(input string req);
    check({req, " mode"}, 32'(mode_id), 32'(exp_id));
    for (int k = 0; k < 3; k++) begin
      logic [16:0] off = (k == 0) ? 17'd0 : (k == 1) ? 17'd2 : 17'($urandom);
      bus_addr = {3'($urandom), off};
      array_rdata = 16'($urandom);
      #1;
      check({req, " rdata"}, 32'(rdata), 32'(exp_rd(exp_id, wide, off, array_rdata)));
    end
  endtask

  logic [19:0] own, other;

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; vpp_ok = 1'b1; wp_sw = 1'b0; wide = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    bus_addr = '0; bus_wdata = '0; array_rdata = 16'h1234;
    own   = {3'(ZIDX), 17'h00000};
    other = {3'd5, 17'h00000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reads("R1");

    // R3: byte mode, high byte ignored
    do_write(own, own, 16'hA590, 1'b1, 1'b0);
    check_reads("R3"); check("R3 id", 32'(mode_id), 32'd1);
    // R4 both widths
    wide = 1'b1; check_reads("R4 wide");
    wide = 1'b0; check_reads("R4 byte");
    // R6 unrecognised keeps mode
    do_write(own, own, 16'h0042, 1'b1, 1'b0);
    check("R6 keep", 32'(mode_id), 32'd1);
    // R5 back to read
    do_write(own, own, 16'h7700, 1'b1, 1'b0);
    check("R5 read", 32'(mode_id), 32'd0); check_reads("R5");
    // R6 word mode mismatched lanes
    wide = 1'b1;
    do_write(own, own, 16'h0090, 1'b1, 1'b0);
    check("R6 wide lanes", 32'(mode_id), 32'd0);
    do_write(own, own, 16'h9090, 1'b1, 1'b0);
    check("R3 wide", 32'(mode_id), 32'd1);
    // R9 pair partner zone accepted in word mode
    do_write({3'd2, 17'h100}, {3'd2, 17'h100}, 16'h0000, 1'b1, 1'b0);
    check("R9 pair", 32'(mode_id), 32'd0);
    wide = 1'b0;
    do_write({3'd2, 17'h100}, {3'd2, 17'h100}, 16'h0090, 1'b1, 1'b0);
    check("R9 byte other", 32'(mode_id), 32'd0);
    // R8 address taken at falling strobe
    do_write(own, other, 16'h0090, 1'b1, 1'b0);
    check("R8 early addr", 32'(mode_id), 32'd1);
    do_write(other, own, 16'h0000, 1'b1, 1'b0);
    check("R8 late addr", 32'(mode_id), 32'd1);
    do_write(own, own, 16'h0000, 1'b0, 1'b0);
    check("R8 ce high", 32'(mode_id), 32'd1);
    // R7 protect for the whole write
    do_write(own, own, 16'h0000, 1'b1, 1'b1);
    check("R7 wp", 32'(mode_id), 32'd1);
    // R7 protect rising in the middle of the strobe
    @(negedge clk); ce_n = 1'b0; bus_addr = own; we_n = 1'b0;
    @(negedge clk); wp_sw = 1'b1; bus_wdata = 16'h0000;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); wp_sw = 1'b0; ce_n = 1'b1;
    @(negedge clk);
    check("R7 wp mid", 32'(mode_id), 32'd1);
    // R10 supply loss
    @(negedge clk); vpp_ok = 1'b0;
    @(negedge clk);
    check("R10 drop", 32'(mode_id), 32'd0); exp_id = 1'b0;
    // R2 writes ignored unpowered
    do_write(own, own, 16'h0090, 1'b1, 1'b0);
    check("R2 unpowered", 32'(mode_id), 32'd0); check_reads("R2");
    vpp_ok = 1'b1;

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      logic [15:0] d;
      int r = $urandom_range(0, 15);
      if (r == 0) begin
        @(negedge clk); vpp_ok = ~vpp_ok;
        @(negedge clk); if (!vpp_ok) exp_id = 1'b0;
        check_reads("R10 rand");
      end else begin
        if (r == 1) wide = ~wide;
        a = {($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'(ZIDX), 17'($urandom)};
        case ($urandom_range(0, 3))
          0: d = wide ? 16'h0000 : {8'($urandom), 8'h00};
          1: d = wide ? 16'h9090 : {8'($urandom), 8'h90};
          default: d = 16'($urandom);
        endcase
        do_write(a, 20'($urandom), d, $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0);
        check_reads("R6 rand");
      end
    end

    // R1 reset from identifier mode
    vpp_ok = 1'b1; wide = 1'b0;
    do_write(own, own, 16'h0090, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0; exp_id = 1'b0;
    #1 check("R1 reset", 32'(mode_id), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reads("R1 after");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule